// File: doc/BRIEF.md
# Bus Error Capture Unit

This block sits beside a parallel bus controller and records six kinds of error event. Each kind has a sticky status bit that software clears by writing 1. The address, command and data of the transaction that raised the first enabled error are frozen in capture registers. Capture stays locked until software has cleared every per-type status bit, and then it re-arms.

A per-type disable mask keeps chosen error kinds from starting a capture, but their status bits are still logged. A multiple-error flag records that a type has occurred again while its own status bit was still set. A single interrupt line is raised while any status bit, the multiple-error flag included, is set.

Register access is a simple port: a 3-bit word address, a write strobe with write data, and read data that follows the address combinationally. Strobe index i maps to status bit 5+i. The index order is: 0 target abort, 1 no response (no target claimed the transaction), 2 target parity, 3 master parity, 4 system-error input, 5 address parity.

Top module: `buserr_log`

## Requirements
- R1: A high on err_evt_i[i] at a clock edge sets status bit 5+i (register address 0), and the bit stays set until it is cleared.
- R2: Writing address 0 clears each status bit in [10:5] whose write-data bit is 1, and leaves bits written with 0 unchanged. If a new event and a clear hit the same bit in one cycle, the bit stays set.
- R3: Status bit 31 (multiple error) is set when err_evt_i[i] is high while status bit 5+i is already 1. Writing 1 to bit 31 at address 0 clears it, and a new recurrence in the same cycle overrides that clear.
- R4: The disable register at address 1 resets to zero. Bits [10:5] are read/write, one bit per type at the same positions as the status bits.
- R5: When no capture is held and an event arrives for a type whose disable bit is 0, the unit captures that cycle's address (address 2), data (address 3) and command (address 4, bits [3:0]), and sets the valid flag (address 4, bit 31).
- R6: While valid is 1, later events never change the captured address, data or command.
- R7: An event of a disabled type still sets its status bit but does not start a capture.
- R8: Several strobes in one cycle set all of their status bits and produce a single capture of that cycle's transaction.
- R9: Valid drops in the cycle in which all six type status bits become zero. After that, the next enabled error is captured again.
- R10: Writes to addresses 2, 3 and 4 have no effect on the captured fields.
- R11: irq_o is the OR of the six status bits and bit 31. It goes high in the cycle after an event.
- R12: Reserved bits of every register read 0, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_evt_i | input | 6 | Error event strobes, one per type |
| txn_addr_i | input | AW | Address of the current transaction |
| txn_cmd_i | input | CW | Command of the current transaction |
| txn_data_i | input | DW | Data of the current transaction |
| reg_addr_i | input | 3 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, follows reg_addr_i |
| irq_o | output | 1 | Summary error interrupt |

## Verification
A wrong internal state shows up at the ports within one clock edge. Status, the multiple flag, valid and the captured fields can all be read combinationally, so the bench reads every register after each cycle. It compares each value against a reference model that tracks the same rules. Faults that only appear across several cycles, such as capture that fails to re-arm or a captured field that gets overwritten, appear on the first read after the triggering event. They do not wait for a later summary.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
  localparam int NTYPE     = 6;
  localparam int STAT_LSB  = 5;
  localparam int STAT_MSB  = STAT_LSB + NTYPE - 1;
  localparam int MULTI_BIT = 31;
  localparam int VALID_BIT = 31;
  localparam int RDW       = 32;
  localparam int RAW       = 3;

  typedef enum logic [RAW-1:0] {
    RA_STAT  = 3'd0,
    RA_DIS   = 3'd1,
    RA_CADDR = 3'd2,
    RA_CDATA = 3'd3,
    RA_CINFO = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/buserr_status.sv
module buserr_status
  import buserr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTYPE-1:0] evt_i,
  input  logic             clr_we_i,
  input  logic [NTYPE-1:0] clr_mask_i,
  input  logic             clr_multi_i,
  output logic [NTYPE-1:0] stat_o,
  output logic [NTYPE-1:0] stat_nxt_o,
  output logic             multi_o
);
  logic [NTYPE-1:0] stat_q, stat_d;
  logic             multi_q, multi_d;
  logic             repeat_hit;

  assign repeat_hit = |(evt_i & stat_q);

  for (genvar i = 0; i < NTYPE; i++) begin : g_bit
    // set wins over a same-cycle clear
    always_comb begin
      stat_d[i] = stat_q[i];
      if (clr_we_i && clr_mask_i[i]) stat_d[i] = 1'b0;
      if (evt_i[i]) stat_d[i] = 1'b1;
    end
  end

  always_comb begin
    multi_d = multi_q;
    if (clr_we_i && clr_multi_i) multi_d = 1'b0;
    if (repeat_hit) multi_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      multi_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      multi_q <= multi_d;
    end
  end

  assign stat_o     = stat_q;
  assign stat_nxt_o = stat_d;
  assign multi_o    = multi_q;

  AST_STAT_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R1
  AST_MULTI_ON_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repeat_hit |=> multi_q); // R3
  AST_STAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2
endmodule

// File: rtl/buserr_capture.sv
module buserr_capture
  import buserr_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTYPE-1:0] evt_i,
  input  logic [NTYPE-1:0] dis_i,
  input  logic [NTYPE-1:0] stat_i,
  input  logic [NTYPE-1:0] stat_nxt_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CW-1:0]    cmd_i,
  input  logic [DW-1:0]    data_i,
  output logic             valid_o,
  output logic [AW-1:0]    addr_o,
  output logic [CW-1:0]    cmd_o,
  output logic [DW-1:0]    data_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cmd_q;
  logic [DW-1:0] data_q;
  logic          take;

  assign take = !valid_q && |(evt_i & ~dis_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
      cmd_q   <= cmd_i;
      data_q  <= data_i;
    end else if (stat_nxt_i == '0) begin
      valid_q <= 1'b0; // re-arm once every type bit is gone
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign cmd_o   = cmd_q;
  assign data_o  = data_q;

  AST_VALID_NEEDS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (|stat_i)); // R9
  AST_CAPTURE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> (!valid_q || ($stable(addr_q) && $stable(cmd_q) && $stable(data_q)))); // R6
  AST_DISABLED_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_q && ((evt_i & ~dis_i) == '0)) |=> !valid_q); // R7
  AST_ENABLED_CAPTURES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_q && (|(evt_i & ~dis_i))) |=> valid_q); // R5
endmodule

// File: rtl/buserr_regif.sv
module buserr_regif
  import buserr_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RAW-1:0]   addr_i,
  input  logic             we_i,
  input  logic [RDW-1:0]   wdata_i,
  output logic [RDW-1:0]   rdata_o,
  input  logic [NTYPE-1:0] stat_i,
  input  logic             multi_i,
  input  logic             cvalid_i,
  input  logic [AW-1:0]    caddr_i,
  input  logic [CW-1:0]    ccmd_i,
  input  logic [DW-1:0]    cdata_i,
  output logic             clr_we_o,
  output logic [NTYPE-1:0] clr_mask_o,
  output logic             clr_multi_o,
  output logic [NTYPE-1:0] dis_o
);
  logic [NTYPE-1:0] dis_q;
  logic             dis_we;
  logic             unused_wdata;

  assign unused_wdata = ^{wdata_i[MULTI_BIT-1:STAT_MSB+1], wdata_i[STAT_LSB-1:0]};

  assign clr_we_o    = we_i && (addr_i == RA_STAT);
  assign clr_mask_o  = wdata_i[STAT_MSB:STAT_LSB];
  assign clr_multi_o = wdata_i[MULTI_BIT];
  assign dis_we      = we_i && (addr_i == RA_DIS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dis_q <= '0;
    else if (dis_we) dis_q <= wdata_i[STAT_MSB:STAT_LSB];
  end

  assign dis_o = dis_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_STAT: begin
        rdata_o[STAT_MSB:STAT_LSB] = stat_i;
        rdata_o[MULTI_BIT]         = multi_i;
      end
      RA_DIS:   rdata_o[STAT_MSB:STAT_LSB] = dis_q;
      RA_CADDR: rdata_o[AW-1:0] = caddr_i;
      RA_CDATA: rdata_o[DW-1:0] = cdata_i;
      RA_CINFO: begin
        rdata_o[CW-1:0]      = ccmd_i;
        rdata_o[VALID_BIT]   = cvalid_i;
      end
      default:  rdata_o = '0;
    endcase
  end

  AST_DIS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_we |=> (dis_q == $past(wdata_i[STAT_MSB:STAT_LSB]))); // R4
  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > RA_CINFO) |-> (rdata_o == '0)); // R12
endmodule

// File: rtl/buserr_log.sv
module buserr_log
  import buserr_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int DW = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NTYPE-1:0]      err_evt_i,
  input  logic [AW-1:0]         txn_addr_i,
  input  logic [CW-1:0]         txn_cmd_i,
  input  logic [DW-1:0]         txn_data_i,
  input  logic [RAW-1:0]        reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [RDW-1:0]        reg_wdata_i,
  output logic [RDW-1:0]        reg_rdata_o,
  output logic                  irq_o
);
  logic [NTYPE-1:0] stat, stat_nxt, clr_mask, dis;
  logic             multi, clr_we, clr_multi, cvalid;
  logic [AW-1:0]    caddr;
  logic [CW-1:0]    ccmd;
  logic [DW-1:0]    cdata;

  buserr_status u_status (
    .clk_i, .rst_ni, .evt_i(err_evt_i), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .clr_multi_i(clr_multi), .stat_o(stat), .stat_nxt_o(stat_nxt), .multi_o(multi)
  );

  buserr_capture #(.AW(AW), .CW(CW), .DW(DW)) u_capture (
    .clk_i, .rst_ni, .evt_i(err_evt_i), .dis_i(dis), .stat_i(stat),
    .stat_nxt_i(stat_nxt), .addr_i(txn_addr_i), .cmd_i(txn_cmd_i),
    .data_i(txn_data_i), .valid_o(cvalid), .addr_o(caddr), .cmd_o(ccmd),
    .data_o(cdata)
  );

  buserr_regif #(.AW(AW), .CW(CW), .DW(DW)) u_regif (
    .clk_i, .rst_ni, .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .stat_i(stat), .multi_i(multi), .cvalid_i(cvalid),
    .caddr_i(caddr), .ccmd_i(ccmd), .cdata_i(cdata), .clr_we_o(clr_we),
    .clr_mask_o(clr_mask), .clr_multi_o(clr_multi), .dis_o(dis)
  );

  assign irq_o = multi | (|stat);

  AST_IRQ_AFTER_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_evt_i) |=> irq_o); // R11
endmodule

// File: tb/sim_buserr_log.sv
`timescale 1ns/1ps
module sim_buserr_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt = '0;
  logic [31:0] t_addr = '0, t_data = '0, wdata = '0;
  logic [3:0]  t_cmd = '0;
  logic [2:0]  raddr = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  logic [5:0]  m_stat = '0, m_dis = '0;
  logic        m_multi = 1'b0, m_cv = 1'b0;
  logic [31:0] m_caddr = '0, m_cdata = '0;
  logic [3:0]  m_ccmd = '0;

  always #2.5 clk = ~clk;

  buserr_log u0 (
    .clk_i(clk), .rst_ni(rst_n), .err_evt_i(evt), .txn_addr_i(t_addr),
    .txn_cmd_i(t_cmd), .txn_data_i(t_data), .reg_addr_i(raddr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_reg(input logic [2:0] a);
    case (a)
      3'd0: return {m_multi, 20'b0, m_stat, 5'b0};
      3'd1: return {21'b0, m_dis, 5'b0};
      3'd2: return m_caddr;
      3'd3: return m_cdata;
      3'd4: return {m_cv, 27'b0, m_ccmd};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R1 R2 R3 status";
      3'd1: return "R4 disable";
      3'd2: return "R5 R6 R10 capture address";
      3'd3: return "R5 R6 R10 capture data";
      3'd4: return "R5 R8 R9 capture info";
      default: return "R12 unmapped";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    for (int a = 0; a < 8; a++) begin
      raddr = a[2:0];
      #0.2;
      chk(req_of(a[2:0]), rdata, exp_reg(a[2:0]));
    end
    chk("R11 irq", {31'b0, irq}, {31'b0, m_multi | (|m_stat)});
  endtask

  // one clock: event e and optional register write; model advanced per requirements
  task automatic cyc(input logic [5:0] e, input logic w, input logic [2:0] wa,
                     input logic [31:0] wd);
    logic [5:0]  ns;
    logic        nm, ncv;
    logic [5:0]  nd;
    logic [31:0] na, ndt;
    logic [3:0]  nc;
    @(negedge clk);
    evt = e; we = w; raddr = wa; wdata = wd;
    t_addr = $urandom; t_data = $urandom; t_cmd = 4'($urandom);
    ns = m_stat; nm = m_multi; nd = m_dis; ncv = m_cv;
    na = m_caddr; ndt = m_cdata; nc = m_ccmd;
    if (w && wa == 3'd0) begin
      ns = ns & ~wd[10:5];
      if (wd[31]) nm = 1'b0;
    end
    ns = ns | e;
    if (|(e & m_stat)) nm = 1'b1;
    if (w && wa == 3'd1) nd = wd[10:5];
    if (!m_cv && |(e & ~m_dis)) begin
      ncv = 1'b1; na = t_addr; ndt = t_data; nc = t_cmd;
    end else if (ns == 6'd0) begin
      ncv = 1'b0;
    end
    @(posedge clk);
    #0.5;
    evt = '0; we = 1'b0;
    m_stat = ns; m_multi = nm; m_dis = nd; m_cv = ncv;
    m_caddr = na; m_cdata = ndt; m_ccmd = nc;
    check_all();
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check_all(); // reset state: R4 disable zero, R12 reserved zero
    // R4 R12: disable write of all ones reads back only [10:5]
    cyc(6'h00, 1'b1, 3'd1, 32'hFFFF_FFFF);
    cyc(6'h00, 1'b1, 3'd1, 32'h0);
    // R7: disabled type logs status without capture
    cyc(6'h00, 1'b1, 3'd1, 32'h0000_0040);
    cyc(6'h02, 1'b0, 3'd0, 32'h0);
    chk("R7 no capture when disabled", {31'b0, m_cv}, 32'h0);
    // R5 R8: two types at once, one capture
    cyc(6'h21, 1'b0, 3'd0, 32'h0);
    // R6 R3: repeat of target abort sets multi, capture kept
    cyc(6'h01, 1'b0, 3'd0, 32'h0);
    // R10: writes to captured fields ignored
    cyc(6'h00, 1'b1, 3'd2, 32'hDEAD_BEEF);
    cyc(6'h00, 1'b1, 3'd3, 32'h1234_5678);
    cyc(6'h00, 1'b1, 3'd4, 32'h0000_000F);
    // R2: set wins over clear on same bit
    cyc(6'h01, 1'b1, 3'd0, 32'h0000_0020);
    // R9: partial clear keeps valid, full clear re-arms
    cyc(6'h00, 1'b1, 3'd0, 32'h0000_0400);
    cyc(6'h00, 1'b1, 3'd0, 32'h8000_07E0);
    chk("R9 re-armed", {31'b0, m_cv}, 32'h0);
    cyc(6'h10, 1'b0, 3'd0, 32'h0);
    chk("R9 new capture", {31'b0, m_cv}, 32'h1);
    cyc(6'h00, 1'b1, 3'd0, 32'h8000_07E0);
    cyc(6'h00, 1'b1, 3'd1, 32'h0);
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [5:0] e;
      for (int b = 0; b < 6; b++) e[b] = ($urandom % 10) == 0;
      if (($urandom % 4) == 0)
        cyc(e, 1'b1, 3'($urandom % 8), $urandom);
      else
        cyc(e, 1'b0, 3'd0, 32'h0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule